// File: doc/BRIEF.md
# Prescaled Compare-Event Timer

This block is a 16-bit up-counting timer that sits behind a small synchronous register port. A slow reference tick, a one-cycle pulse in the system clock domain that nominally arrives 32768 times a second, drives a power-of-two prescaler. The counter steps once every 2^scale reference ticks, so a scale of 4 gives 2048 counts per second. Two comparators watch the counter. When the counter steps onto a compare value, a sticky flag is set. A flag whose event mode is enabled drives the level-sensitive interrupt output.

One control word holds the run bit, the prescale exponent, the event mode of each comparator and both match flags. The flags are cleared by writing one to them. Because of this, software can stop the timer and drop any pending event with a single write. A typical handler reads the control word to confirm that the event belongs to it, then writes the flag bit back to clear it. After that it rewrites the counter, and for periodic use it sets the run bit again. The counter never halts on a match. It wraps from 0xFFFF to zero and keeps counting.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq` is low: the counter is stopped, no event is enabled and no flag is set.
- R2: The register map is: address 0 the counter, 1 compare 1, 2 compare 2, 3 the control word. Compare registers read back the value last written.
- R3: Control word fields: bit 15 run, bit 14 compare 2 flag, bit 13 compare 1 flag, bits 9:8 compare 2 event mode, bits 7:6 compare 1 event mode, bits 3:0 scale. All other bits read 0.
- R4: While run is 1, the counter steps by one on every 2^scale-th reference tick. The prescale phase starts from zero when the counter is written and while run is 0.
- R5: While run is 0, reference ticks leave the counter unchanged.
- R6: A write to the counter loads the written value, and writing 0 restarts counting from zero.
- R7: The counter wraps from 0xFFFF to 0x0000 and continues counting.
- R8: When the counter steps onto the compare 2 value, flag bit 14 is set. It stays set after the counter moves on, and counting does not stop. Loading a value by a write does not count as a match.
- R9: When the counter steps onto the compare 1 value, flag bit 13 is set in the same way.
- R10: In a control word write, a 1 in a flag bit clears that flag and a 0 leaves it unchanged. If a match and a clear fall in the same cycle, the flag stays set.
- R11: `irq` is high exactly while a flag is set and its event mode equals 3. A flag whose mode is anything else is still set but does not raise `irq`.
- R12: A single control word write with run 0, modes 0 and both flag bits 1 stops the counter, clears both flags and drops `irq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle reference tick pulse |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `refTick` is a synchronous pulse no longer than one clock. They also assume that a write and a reference step landing in the same cycle resolve as the requirements state: the write wins for the counter, and the match wins for a flag. The stimulus drives every input on the falling edge. It separates ticks from one another by an idle cycle and never issues a write in a cycle that carries a tick. Each interval and every flag clear is therefore unambiguous.

// File: rtl/cet_pkg.sv
package cet_pkg;
  localparam int REG_W   = 16;
  localparam int SCALE_W = 4;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CMP1  = 2'd1;
  localparam logic [1:0] ADDR_CMP2  = 2'd2;
  localparam logic [1:0] ADDR_SETUP = 2'd3;

  localparam int RUN_BIT   = 15;
  localparam int FLAG2_BIT = 14;
  localparam int FLAG1_BIT = 13;
  localparam int MODE2_LO  = 8;
  localparam int MODE1_LO  = 6;

  localparam logic [1:0] MODE_IRQ = 2'b11;

  typedef struct packed {
    logic               cntLoad;
    logic               cmp1Load;
    logic               cmp2Load;
    logic               countEn;
    logic [SCALE_W-1:0] scale;
  } dpStrobes_t;
endpackage

// File: rtl/cet_datapath.sv
module cet_datapath
  import cet_pkg::*;
#(
  parameter int CNT_W   = REG_W,
  parameter int SCALE_BITS = SCALE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  dpStrobes_t       ctl,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] cmp1Val,
  output logic [CNT_W-1:0] cmp2Val,
  output logic [1:0]       matchVec
);
  localparam int PRE_W = (1 << SCALE_BITS) - 1;
  localparam int NUM_CMP = 2;

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preMask;
  logic             preWrap;
  logic             step;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] cmpQ [NUM_CMP];
  logic [NUM_CMP-1:0] loadVec;

  // Divisor 2^scale: the prescale phase wraps when it equals (2^scale)-1.
  assign preMask = ~({PRE_W{1'b1}} << ctl.scale);
  assign preWrap = (preQ == preMask);
  assign step    = ctl.countEn && refTick && preWrap && !ctl.cntLoad;
  assign cntNext = cntQ + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.countEn || ctl.cntLoad) begin
      preQ <= '0;
    end else if (refTick) begin
      preQ <= preWrap ? '0 : preQ + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.cntLoad) begin
      cntQ <= wrData;
    end else if (step) begin
      cntQ <= cntNext;
    end
  end

  assign loadVec = {ctl.cmp2Load, ctl.cmp1Load};

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[gi] <= '0;
      end else if (loadVec[gi]) begin
        cmpQ[gi] <= wrData;
      end
    end
    // A match is the counter stepping onto the compare value.
    assign matchVec[gi] = step && (cntNext == cmpQ[gi]);
  end

  assign countVal = cntQ;
  assign cmp1Val  = cmpQ[0];
  assign cmp2Val  = cmpQ[1];

  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.countEn && !ctl.cntLoad) |=> $stable(cntQ));

  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && refTick && preWrap && !ctl.cntLoad) |=> (cntQ == $past(cntQ) + CNT_W'(1)));

  a_r6_load_value: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntLoad |=> (cntQ == $past(wrData)));

  a_r4_no_step_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!refTick && !ctl.cntLoad) |=> $stable(cntQ));
endmodule

// File: rtl/cet_ctrl.sv
module cet_ctrl
  import cet_pkg::*;
#(
  parameter int CNT_W   = REG_W,
  parameter int SCALE_BITS = SCALE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] countVal,
  input  logic [CNT_W-1:0] cmp1Val,
  input  logic [CNT_W-1:0] cmp2Val,
  input  logic [1:0]       matchVec,
  output dpStrobes_t       ctl,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);
  logic                  runQ;
  logic [SCALE_BITS-1:0] scaleQ;
  logic [1:0]            mode1Q;
  logic [1:0]            mode2Q;
  logic [1:0]            flagQ;
  logic [1:0]            clrVec;
  logic [1:0]            irqEnVec;
  logic                  setupWr;
  logic [CNT_W-1:0]      setupWord;

  assign setupWr = wrEn && (regAddr == ADDR_SETUP);
  assign clrVec  = setupWr ? {wrData[FLAG2_BIT], wrData[FLAG1_BIT]} : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      scaleQ <= '0;
      mode1Q <= '0;
      mode2Q <= '0;
    end else if (setupWr) begin
      runQ   <= wrData[RUN_BIT];
      scaleQ <= wrData[SCALE_BITS-1:0];
      mode1Q <= wrData[MODE1_LO +: 2];
      mode2Q <= wrData[MODE2_LO +: 2];
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[gi] <= 1'b0;
      end else begin
        flagQ[gi] <= matchVec[gi] | (flagQ[gi] & ~clrVec[gi]);
      end
    end
  end

  assign irqEnVec = {mode2Q == MODE_IRQ, mode1Q == MODE_IRQ};
  assign irq      = |(flagQ & irqEnVec);

  always_comb begin
    ctl          = '0;
    ctl.cntLoad  = wrEn && (regAddr == ADDR_COUNT);
    ctl.cmp1Load = wrEn && (regAddr == ADDR_CMP1);
    ctl.cmp2Load = wrEn && (regAddr == ADDR_CMP2);
    ctl.countEn  = runQ;
    ctl.scale    = scaleQ;
  end

  always_comb begin
    setupWord                    = '0;
    setupWord[RUN_BIT]           = runQ;
    setupWord[FLAG2_BIT]         = flagQ[1];
    setupWord[FLAG1_BIT]         = flagQ[0];
    setupWord[MODE2_LO +: 2]     = mode2Q;
    setupWord[MODE1_LO +: 2]     = mode1Q;
    setupWord[SCALE_BITS-1:0]    = scaleQ;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_COUNT: rdData = countVal;
      ADDR_CMP1:  rdData = cmp1Val;
      ADDR_CMP2:  rdData = cmp2Val;
      default:    rdData = setupWord;
    endcase
  end

  a_r8_flag_from_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[1]) |-> $past(matchVec[1]));

  a_r9_flag_from_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[0]) |-> $past(matchVec[0]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[1] && !(setupWr && wrData[FLAG2_BIT])) |=> flagQ[1]);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (setupWr && wrData[FLAG2_BIT] && !matchVec[1]) |=> !flagQ[1]);

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ != 2'b00));
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             wrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  dpStrobes_t       ctl;
  logic [REG_W-1:0] countVal;
  logic [REG_W-1:0] cmp1Val;
  logic [REG_W-1:0] cmp2Val;
  logic [1:0]       matchVec;

  cet_ctrl #(.CNT_W(REG_W), .SCALE_BITS(SCALE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .countVal(countVal), .cmp1Val(cmp1Val), .cmp2Val(cmp2Val),
    .matchVec(matchVec), .ctl(ctl), .rdData(rdData), .irq(irq)
  );

  cet_datapath #(.CNT_W(REG_W), .SCALE_BITS(SCALE_W)) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .ctl(ctl), .wrData(wrData),
    .countVal(countVal), .cmp1Val(cmp1Val), .cmp2Val(cmp2Val),
    .matchVec(matchVec)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> (!irq && countVal == '0));
endmodule

// File: tb/cmp_event_timer_bench.sv
module cmp_event_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RUN = 16'h8000;
  localparam logic [15:0] F2  = 16'h4000;
  localparam logic [15:0] F1  = 16'h2000;
  localparam logic [15:0] M2I = 16'h0300;
  localparam logic [15:0] M1I = 16'h00C0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_event_timer u_cmp_event_timer (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refTick = 1'b1;
      @(negedge clk); refTick = 1'b0;
    end
  endtask

  task automatic test_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);
    tick(3);
    rd(2'd0, v);
    chk("R5 stopped after reset", v, 16'h0000);
  endtask

  task automatic test_regmap();
    logic [15:0] v;
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'hBEEF);
    rd(2'd1, v); chk("R2 compare 1 readback", v, 16'h1234);
    rd(2'd2, v); chk("R2 compare 2 readback", v, 16'hBEEF);
    wr(2'd3, 16'hFFFF & ~(F2 | F1));
    rd(2'd3, v); chk("R3 control word fields", v, 16'h83CF);
    wr(2'd3, 16'h0000);
  endtask

  task automatic test_prescale();
    logic [15:0] v;
    wr(2'd3, RUN | 16'd2);
    wr(2'd0, 16'h0000);
    tick(3);
    rd(2'd0, v); chk("R4 scale 2 before fourth tick", v, 16'h0000);
    tick(1);
    rd(2'd0, v); chk("R4 scale 2 first step", v, 16'h0001);
    tick(8);
    rd(2'd0, v); chk("R4 scale 2 after twelve ticks", v, 16'h0003);
    wr(2'd3, RUN | 16'd0);
    wr(2'd0, 16'h0000);
    tick(5);
    rd(2'd0, v); chk("R4 scale 0 every tick", v, 16'h0005);
    wr(2'd3, RUN | 16'd4);
    wr(2'd0, 16'h0000);
    tick(15);
    rd(2'd0, v); chk("R4 scale 4 before sixteenth tick", v, 16'h0000);
    tick(1);
    rd(2'd0, v); chk("R4 scale 4 first step", v, 16'h0001);
  endtask

  task automatic test_stop_load();
    logic [15:0] v;
    wr(2'd3, 16'd0);
    wr(2'd0, 16'h0042);
    rd(2'd0, v); chk("R6 counter load", v, 16'h0042);
    tick(4);
    rd(2'd0, v); chk("R5 stopped counter holds", v, 16'h0042);
    wr(2'd3, RUN);
    tick(2);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R6 write zero restarts", v, 16'h0000);
    tick(1);
    rd(2'd0, v); chk("R6 counts up from zero", v, 16'h0001);
    wr(2'd0, 16'hFFFE);
    tick(2);
    rd(2'd0, v); chk("R7 wrap to zero", v, 16'h0000);
    tick(1);
    rd(2'd0, v); chk("R7 continues after wrap", v, 16'h0001);
    wr(2'd3, 16'd0);
  endtask

  task automatic test_match();
    logic [15:0] v;
    wr(2'd1, 16'h7000);
    wr(2'd2, 16'h000F);
    wr(2'd0, 16'h000D);
    wr(2'd3, RUN | M2I);
    tick(1);
    rd(2'd3, v); chk("R8 no flag before match", v & F2, 16'h0000);
    chk("R11 irq low before match", {15'd0, irq}, 16'h0000);
    tick(1);
    rd(2'd3, v); chk("R8 flag on step onto compare 2", v & F2, F2);
    chk("R11 irq with mode 3", {15'd0, irq}, 16'h0001);
    tick(1);
    rd(2'd0, v); chk("R8 counting continues", v, 16'h0010);
    rd(2'd3, v); chk("R8 flag sticky", v & F2, F2);
    wr(2'd3, RUN | M2I);
    rd(2'd3, v); chk("R10 write 0 keeps flag", v & F2, F2);
    wr(2'd3, RUN | M2I | F2);
    rd(2'd3, v); chk("R10 write 1 clears flag", v & F2, 16'h0000);
    chk("R11 irq drops", {15'd0, irq}, 16'h0001 & 16'h0000);
    wr(2'd0, 16'h000F);
    rd(2'd3, v); chk("R8 load onto compare is no match", v & F2, 16'h0000);
    // upper usable interval
    wr(2'd2, 16'hFFFE);
    wr(2'd0, 16'hFFFD);
    tick(1);
    rd(2'd3, v); chk("R8 match at 0xFFFE", v & F2, F2);
    wr(2'd3, RUN | F2);
    // compare 1 with mode 0: flag but no irq
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0002);
    tick(1);
    rd(2'd3, v); chk("R9 compare 1 flag", v & F1, F1);
    chk("R11 mode 0 no irq", {15'd0, irq}, 16'h0000);
    wr(2'd3, RUN | M1I);
    chk("R11 compare 1 irq with mode 3", {15'd0, irq}, 16'h0001);
  endtask

  task automatic test_oneshot_clear();
    logic [15:0] v;
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h0004);
    wr(2'd3, RUN | M1I | M2I);
    tick(1);
    rd(2'd3, v); chk("R12 both flags pending", v & (F1 | F2), F1 | F2);
    wr(2'd3, F1 | F2);
    rd(2'd3, v); chk("R12 single write clears all", v, 16'h0000);
    chk("R12 irq low", {15'd0, irq}, 16'h0000);
    tick(3);
    rd(2'd0, v); chk("R12 counter stopped", v, 16'h0005);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regmap();
    test_prescale();
    test_stop_load();
    test_match();
    test_oneshot_clear();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule